// File: doc/BRIEF.md
# Lockable Countdown Reset Watchdog

This block is a countdown watchdog for a power-management die. Software programs a 32-bit reload value as two 16-bit halves, then sets a run bit. From that point the counter steps down once per pulse of a 32.768 kHz timebase strobe. When the count runs out, the block does one of two things. If reset generation is enabled, it drives a system reset for a fixed number of timebase periods and stops. Otherwise it raises a sticky expiry flag that also drives an interrupt line, reloads, and keeps counting.

A 16-bit key guards the reload and control registers. Writes to them take effect only after 0xE551 has been written to the lock register. Writing any other value to the lock register protects them again. A reload value of 1638 gives roughly 50 ms at the 32.768 kHz rate.

The register bus is a simple synchronous read/write port. Read data is registered and holds between reads.

Top module: `wdt_guard`

## Requirements
- R1: After reset the block is locked, every register reads 0, and `sys_rst_o` and `irq_o` are low.
- R2: Writing 0xE551 in bits 15:0 to the lock register (offset 0x20) unlocks. Writing any other value locks. The lock register reads 1 when unlocked and 0 when locked.
- R3: While locked, writes to offsets 0x00, 0x04 and 0x08 have no effect on any register or on the flag.
- R4: Offset 0x00 stores bits 15:0 of the reload value and offset 0x04 stores bits 31:16, each from `wdata[15:0]`. Upper write bits are dropped, and both offsets read back zero-extended.
- R5: Control (offset 0x08) uses bit 1 for run, bit 2 for a mode bit (stored only) and bit 3 for reset enable. Bit 4 reads as the expiry flag, and writing 1 to bit 4 clears it. All other bits read 0.
- R6: A 0-to-1 change of run loads the 32-bit reload value, and each later tick lowers the count by one. The count expires on the tick that finds it at 1 or 0, so a reload value N (N ≥ 1) expires on the Nth tick and a reload value of 0 expires on the first.
- R7: An expiry with reset enable set raises `sys_rst_o` one clock after the tick edge. It stays high for 4 further tick periods, the run bit clears, and no further expiry occurs.
- R8: An expiry with reset enable clear sets the flag, which drives `irq_o` one clock after the tick edge. The count then reloads and keeps running, and the flag stays set until cleared.
- R9: Read data appears on `rdata` one clock after `rd_en` and holds while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe at the 32.768 kHz timebase rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| irq_o | output | 1 | Level interrupt from the sticky expiry flag |

## Verification
Register writes land on the clock edge of the write strobe. A read returns data one edge after `rd_en`, so the bench samples `rdata` at the falling edge after that. The counter loads on the edge after the run bit is written, so the bench waits two idle clocks before the first tick. Expiry reaches `sys_rst_o`, `irq_o` and the control register one clock after the tick edge, and every tick is followed by an idle clock, so all checks sample at a falling edge after that idle clock.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = 16;
  localparam int LOAD_W   = 2 * HALF_W;

  localparam logic [ADDR_W-1:0] OFF_LOAD_LO = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_LOAD_HI = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_LOCK    = 6'h20;

  localparam int CB_RUN   = 1;
  localparam int CB_MODE  = 2;
  localparam int CB_RSTEN = 3;
  localparam int CB_FLAG  = 4;

  localparam logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551;

  typedef struct packed {
    logic flag;
    logic rst_en;
    logic mode;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire_rst_i,
  input  logic              expire_irq_i,
  output logic [DATA_W-1:0] rdata,
  output logic [LOAD_W-1:0] load_val_o,
  output logic              run_o,
  output logic              rst_en_o,
  output logic              irq_o
);
  logic              unlocked_q;
  logic [HALF_W-1:0] lo_q, hi_q;
  ctrl_t             ctrl_q;
  logic              wr_ok;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ok = wr_en && unlocked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked_q <= 1'b0;
    end else if (wr_en && addr == OFF_LOCK) begin
      unlocked_q <= (wdata[HALF_W-1:0] == UNLOCK_KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_ok) begin
      if (addr == OFF_LOAD_LO) lo_q <= wdata[HALF_W-1:0];
      if (addr == OFF_LOAD_HI) hi_q <= wdata[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ok && addr == OFF_CTRL) begin
        ctrl_q.run    <= wdata[CB_RUN];
        ctrl_q.mode   <= wdata[CB_MODE];
        ctrl_q.rst_en <= wdata[CB_RSTEN];
        if (wdata[CB_FLAG]) ctrl_q.flag <= 1'b0;
      end
      if (expire_rst_i) ctrl_q.run  <= 1'b0;
      if (expire_irq_i) ctrl_q.flag <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_LOAD_LO: rd_mux[HALF_W-1:0] = lo_q;
      OFF_LOAD_HI: rd_mux[HALF_W-1:0] = hi_q;
      OFF_CTRL: begin
        rd_mux[CB_RUN]   = ctrl_q.run;
        rd_mux[CB_MODE]  = ctrl_q.mode;
        rd_mux[CB_RSTEN] = ctrl_q.rst_en;
        rd_mux[CB_FLAG]  = ctrl_q.flag;
      end
      OFF_LOCK: rd_mux[0] = unlocked_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign load_val_o = {hi_q, lo_q};
  assign run_o      = ctrl_q.run;
  assign rst_en_o   = ctrl_q.rst_en;
  assign irq_o      = ctrl_q.flag;

  // R3: a locked write to the low half leaves it unchanged
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!unlocked_q && wr_en && addr == OFF_LOAD_LO) |=> $stable(lo_q));

  // R8: the flag stays set unless an unlocked write clears it
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.flag && !(wr_ok && addr == OFF_CTRL && wdata[CB_FLAG])) |=> ctrl_q.flag);

  // R7: a reset-mode expiry leaves run cleared
  p_run_clear_r7: assert property (@(posedge clk) disable iff (rst)
    expire_rst_i |=> !ctrl_q.run);

  // R9: read data holds while no read is issued
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run_i,
  input  logic              rst_en_i,
  input  logic [LOAD_W-1:0] load_val_i,
  output logic              expire_rst_o,
  output logic              expire_irq_o
);
  logic [LOAD_W-1:0] cnt_q;
  logic              run_d;
  logic              armed_q;
  logic              start;
  logic              spent;

  assign start = run_i && !run_d;
  assign spent = (cnt_q <= LOAD_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      run_d        <= 1'b0;
      armed_q      <= 1'b0;
      expire_rst_o <= 1'b0;
      expire_irq_o <= 1'b0;
    end else begin
      run_d        <= run_i;
      expire_rst_o <= 1'b0;
      expire_irq_o <= 1'b0;
      if (start) begin
        cnt_q   <= load_val_i;
        armed_q <= 1'b1;
      end else if (tick && run_i && armed_q) begin
        if (spent) begin
          if (rst_en_i) begin
            armed_q      <= 1'b0;
            expire_rst_o <= 1'b1;
          end else begin
            cnt_q        <= load_val_i;
            expire_irq_o <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - LOAD_W'(1);
        end
      end
    end
  end

  // R7: a reset-mode expiry fires once and does not repeat on the next clock
  p_single_expire_r7: assert property (@(posedge clk) disable iff (rst)
    expire_rst_o |=> !expire_rst_o);

  // R6: nothing expires without a tick on the previous clock
  p_expire_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (expire_rst_o || expire_irq_o) |-> $past(tick));
endmodule

// File: rtl/wdt_rstgen.sv
module wdt_rstgen #(
  parameter int PULSE_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic expire_i,
  output logic sys_rst_o
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      sys_rst_o <= 1'b0;
    end else if (expire_i) begin
      left_q    <= CW'(PULSE_TICKS);
      sys_rst_o <= 1'b1;
    end else if (tick && left_q != '0) begin
      left_q <= left_q - CW'(1);
      if (left_q == CW'(1)) sys_rst_o <= 1'b0;
    end
  end

  // R7: the reset output only rises after an expiry
  p_rst_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(expire_i));

  // R7: the reset output only falls on a tick
  p_rst_fall_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_o) |-> $past(tick));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int PULSE_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_rst_o,
  output logic              irq_o
);
  logic [LOAD_W-1:0] load_val;
  logic              run, rst_en, exp_rst, exp_irq;

  wdt_regs u_regs (
    .clk, .rst, .wr_en, .rd_en, .addr, .wdata,
    .expire_rst_i(exp_rst), .expire_irq_i(exp_irq),
    .rdata, .load_val_o(load_val), .run_o(run), .rst_en_o(rst_en), .irq_o
  );

  wdt_core u_core (
    .clk, .rst, .tick, .run_i(run), .rst_en_i(rst_en), .load_val_i(load_val),
    .expire_rst_o(exp_rst), .expire_irq_o(exp_irq)
  );

  wdt_rstgen #(.PULSE_TICKS(PULSE_TICKS)) u_rstgen (
    .clk, .rst, .tick, .expire_i(exp_rst), .sys_rst_o
  );
endmodule

// File: tb/wdt_guard_tb.sv
module wdt_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // {write?, offset, data-or-expected}
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 8'h20, 32'h0000_0000},
    {1'b1, 8'h00, 32'h0000_1234},
    {1'b0, 8'h00, 32'h0000_0000},
    {1'b1, 8'h20, 32'h0000_E551},
    {1'b0, 8'h20, 32'h0000_0001},
    {1'b1, 8'h00, 32'hABCD_1234},
    {1'b0, 8'h00, 32'h0000_1234},
    {1'b1, 8'h04, 32'hFFFF_0002},
    {1'b0, 8'h04, 32'h0000_0002},
    {1'b1, 8'h08, 32'h0000_0005},
    {1'b0, 8'h08, 32'h0000_0004},
    {1'b1, 8'h20, 32'h0000_1AAE},
    {1'b0, 8'h20, 32'h0000_0000},
    {1'b1, 8'h08, 32'h0000_0000},
    {1'b0, 8'h08, 32'h0000_0004},
    {1'b1, 8'h04, 32'h0000_0055}
  };

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic        sys_rst_o, irq_o;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard u_dut (
    .clk, .rst, .tick, .wr_en, .rd_en, .addr, .wdata, .rdata, .sys_rst_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(posedge clk); @(negedge clk);
      tick = 1'b0; @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic start_run(input logic [31:0] ctl);
    wr(6'h08, ctl); idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); idle(2); rst = 1'b0; idle(1);
    // R1 reset outputs
    check("R1 sys_rst_o", {31'b0, sys_rst_o}, 0);
    check("R1 irq_o", {31'b0, irq_o}, 0);

    // Table: R1 R2 R3 R4 R5 register behaviour
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][40]) wr(VEC[k][37:32], VEC[k][31:0]);
      else begin
        rd(VEC[k][37:32], rv);
        check($sformatf("R2 R3 R4 R5 vector %0d", k), rv, VEC[k][31:0]);
      end
    end
    rd(6'h04, rv); check("R3 locked high half", rv, 32'h2);
    idle(2); check("R9 rdata holds", rdata, 32'h2);

    // R1 reset clears everything
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    rd(6'h00, rv); check("R1 low half", rv, 0);
    rd(6'h04, rv); check("R1 high half", rv, 0);
    rd(6'h08, rv); check("R1 control", rv, 0);
    rd(6'h20, rv); check("R1 lock", rv, 0);

    // R6 R7 reset-mode expiry
    wr(6'h20, 32'hE551); wr(6'h00, 3); wr(6'h04, 0);
    start_run(32'h0A);
    ticks(2); check("R6 no early expiry", {31'b0, sys_rst_o}, 0);
    ticks(1); check("R7 reset asserted", {31'b0, sys_rst_o}, 1);
    rd(6'h08, rv); check("R7 run cleared", rv, 32'h08);
    ticks(3); check("R7 reset held", {31'b0, sys_rst_o}, 1);
    ticks(1); check("R7 reset released", {31'b0, sys_rst_o}, 0);
    ticks(4); check("R7 no re-expiry", {31'b0, sys_rst_o}, 0);
    check("R8 no flag in reset mode", {31'b0, irq_o}, 0);

    // R8 interrupt-mode expiry
    wr(6'h00, 2); start_run(32'h02);
    ticks(1); check("R8 irq not yet", {31'b0, irq_o}, 0);
    ticks(1); check("R8 irq set", {31'b0, irq_o}, 1);
    check("R8 no reset", {31'b0, sys_rst_o}, 0);
    rd(6'h08, rv); check("R5 R8 control flag+run", rv, 32'h12);
    ticks(2); check("R8 flag sticky", {31'b0, irq_o}, 1);
    wr(6'h08, 32'h12); check("R5 flag cleared", {31'b0, irq_o}, 0);

    // R3 locked control
    wr(6'h20, 32'hFFFF_1AAE); wr(6'h08, 0);
    rd(6'h08, rv); check("R3 control kept", rv, 32'h02);
    ticks(2); check("R8 reload expired again", {31'b0, irq_o}, 1);
    wr(6'h08, 32'h10); check("R3 locked clear ignored", {31'b0, irq_o}, 1);

    // R6 reload on a new run edge
    wr(6'h20, 32'hE551); wr(6'h08, 32'h10);
    wr(6'h00, 3); start_run(32'h02);
    ticks(1); wr(6'h08, 0); idle(1); start_run(32'h02);
    ticks(2); check("R6 reloaded on restart", {31'b0, irq_o}, 0);
    ticks(1); check("R6 expiry after reload", {31'b0, irq_o}, 1);

    // R4 upper half counts
    wr(6'h08, 32'h10); wr(6'h00, 2); wr(6'h04, 1); start_run(32'h02);
    ticks(3); check("R4 upper half extends count", {31'b0, irq_o}, 0);

    // R6 zero load expires on first tick
    wr(6'h08, 32'h10); wr(6'h00, 0); wr(6'h04, 0); start_run(32'h02);
    ticks(1); check("R6 zero load", {31'b0, irq_o}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule